// File: doc/BRIEF.md
# Register-Driven Two-Wire Byte Master

This block lets a host move one byte to or from a device on a two-wire serial bus (clock and data, both open-drain) by programming four small registers. The host loads a byte-address (index) register and, for a write, the data register. It then writes the slave-address register with a 7-bit device address and a direction bit. That one write launches the whole transaction. The master issues the start condition, the device address, the sub-address byte and either the data byte or a repeated start followed by a one-byte read. It checks every acknowledge and ends with a stop.

The host learns that the transaction is over by polling a busy flag in the control/status register. After a read, the returned byte sits in the data register. A missing acknowledge cuts the transaction short with a stop and raises a sticky error flag, which the host clears by writing 1 to it. The bus clock comes from the system clock through a parameterised divider. Each bus bit lasts four divider ticks.

Top module: `sbus_byte_master`

## Requirements
- R1: After reset the control/status register (offset 3) and the data register (offset 0) read 0, and both bus lines are released (`scl_oe` = 0, `sda_oe` = 0). The bus stays released whenever the busy flag is 0.
- R2: A host write to the slave-address register (offset 2) while idle makes the busy flag (offset 3, bit 5) read 1 on the next cycle. The flag stays 1 until the transaction has ended.
- R3: With bit 0 of the slave-address value equal to 0, the master sends the following in order: start, address byte {addr[6:0], 0}, the index byte, the data byte, stop. Each byte's acknowledge is checked, and the addressed device receives the data byte at the index.
- R4: With bit 0 equal to 1, the master sends the following in order: start, {addr, 0}, the index byte, repeated start, {addr, 1}. It then reads one byte MSB first, answers it with a not-acknowledge and sends stop. Once busy reads 0, the data register holds the byte returned by the device.
- R5: While busy, host writes to the data, index and slave-address registers have no effect. They neither change the register contents nor start another transaction.
- R6: When the device does not acknowledge its address, the transaction ends with a stop and the bus is released. Error bit 4 of offset 3 then reads 1, busy reads 0, and nothing is written in the device.
- R7: When the device does not acknowledge the data byte of a write, error bit 4 reads 1 once busy clears, and the bus ends with a stop.
- R8: The error bit holds its value until the host writes offset 3 with bit 4 set. A write with bit 4 clear leaves it set.
- R9: Inside a transaction, the data line changes while the clock line is high only to form start, repeated-start and stop conditions.
- R10: The bus clock period is 4 × `CLK_DIV` system clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Host register write strobe |
| reg_addr | input | 2 | Host register offset: 0 data, 1 index, 2 slave address, 3 control/status |
| reg_wdata | input | 8 | Host write data |
| reg_rdata | output | 8 | Read data of the register selected by `reg_addr` (combinational) |
| scl_oe | output | 1 | 1 pulls the bus clock line low, 0 releases it |
| sda_oe | output | 1 | 1 pulls the bus data line low, 0 releases it |
| sda_in | input | 1 | Level sensed on the bus data line |

## Verification
The bench attaches a behavioural bus device with a 16-byte memory and checks three kinds of result: what that memory holds, what the host registers read back, and how many start and stop conditions appear on the wires. The first corner case is a write to the slave-address register during a busy transaction. A design that accepts it would start a second transfer or corrupt the index, and the start count or the device memory would show it. The second is a device that stays silent on its address and a device that rejects the data byte. A design that misses either would report success or leave the bus held. The bench also checks that a write of 0 does not clear the error flag. Finally, a read that follows a failed write must still fetch the right byte. This catches a design that swaps the two address-byte direction bits or skips the repeated start.

// File: rtl/sbm_pkg.sv
`timescale 1ns/1ps
// Package: shared constants and state types of the two-wire byte master.
// Assumes a byte-wide host register file with four offsets.
package sbm_pkg;
    localparam int DW        = 8;
    localparam int AW        = 2;
    localparam int BUSY_BIT  = 5;
    localparam int ERR_BIT   = 4;

    localparam logic [AW-1:0] OFS_DATA  = 2'd0;
    localparam logic [AW-1:0] OFS_INDEX = 2'd1;
    localparam logic [AW-1:0] OFS_SLAVE = 2'd2;
    localparam logic [AW-1:0] OFS_CTRL  = 2'd3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_TX,
        ST_RSTART,
        ST_RX,
        ST_STOP
    } eng_state_e;

    typedef enum logic [1:0] {
        SEG_ADDRW,
        SEG_INDEX,
        SEG_DATA,
        SEG_ADDRR
    } tx_seg_e;
endpackage

// File: rtl/sbm_tick.sv
`timescale 1ns/1ps
// Module: quarter-bit tick generator.
// Emits a one-cycle tick every DIV system clocks; each bus bit spans four
// ticks. Assumes DIV >= 2.
module sbm_tick #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    // Free-running divider counter with a terminal-count tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            tick  <= 1'b0;
        end else begin
            tick <= (cnt_q == LAST);
            if (cnt_q == LAST) cnt_q <= '0;
            else               cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/sbm_regs.sv
`timescale 1ns/1ps
// Module: host register file.
// Holds data, index and slave-address registers plus busy and sticky error
// flags. A slave-address write while idle sets busy and pulses go. Host
// writes to the first three registers are dropped while busy. Assumes the
// engine returns exactly one done pulse per go.
module sbm_regs
    import sbm_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic          done,
    input  logic          done_err,
    input  logic          done_read,
    input  logic [DW-1:0] rx_byte,
    output logic          go,
    output logic          busy,
    output logic          err,
    output logic [DW-1:0] data_q,
    output logic [DW-1:0] index_q,
    output logic [DW-1:0] slave_q
);
    logic err_clear;
    assign err_clear = reg_wr && (reg_addr == OFS_CTRL) && reg_wdata[ERR_BIT];

    // Register updates: host writes, launch, and completion capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q  <= '0;
            index_q <= '0;
            slave_q <= '0;
            busy    <= 1'b0;
            err     <= 1'b0;
            go      <= 1'b0;
        end else begin
            go <= 1'b0;
            if (reg_wr && !busy) begin
                unique case (reg_addr)
                    OFS_DATA:  data_q  <= reg_wdata;
                    OFS_INDEX: index_q <= reg_wdata;
                    OFS_SLAVE: begin
                        slave_q <= reg_wdata;
                        busy    <= 1'b1;
                        go      <= 1'b1;
                    end
                    default: ;
                endcase
            end
            if (err_clear) err <= 1'b0;
            if (done) begin
                busy <= 1'b0;
                if (done_err)       err    <= 1'b1;
                else if (done_read) data_q <= rx_byte;
            end
        end
    end

    // Host read multiplexer.
    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            OFS_DATA:  reg_rdata = data_q;
            OFS_INDEX: reg_rdata = index_q;
            OFS_SLAVE: reg_rdata = slave_q;
            default: begin
                reg_rdata[BUSY_BIT] = busy;
                reg_rdata[ERR_BIT]  = err;
            end
        endcase
    end
endmodule

// File: rtl/sbm_engine.sv
`timescale 1ns/1ps
// Module: bus sequencing engine.
// Runs one write or random-read byte transaction per go pulse. Each bus bit
// takes four ticks: q0 pull clock low, q1 set data, q2 release clock,
// q3 sample data. Assumes the register inputs stay constant while it runs
// and that no other master or clock stretching is present.
module sbm_engine
    import sbm_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          go,
    input  logic [DW-1:0] slave_byte,
    input  logic [DW-1:0] index_byte,
    input  logic [DW-1:0] data_byte,
    input  logic          sda_in,
    output logic          scl_oe,
    output logic          sda_oe,
    output logic          done,
    output logic          done_err,
    output logic          done_read,
    output logic [DW-1:0] rx_byte,
    output logic          in_data
);
    localparam int BCW = $clog2(DW + 1);
    localparam logic [BCW-1:0] ACK_SLOT = BCW'(DW);

    eng_state_e     st_q;
    tx_seg_e        seg_q;
    logic [1:0]     q_q;
    logic [BCW-1:0] bitn_q;
    logic [DW-1:0]  sh_q;
    logic           rd_q;
    logic           err_q;

    assign done_err  = err_q;
    assign done_read = rd_q;
    assign in_data   = (st_q == ST_TX) || (st_q == ST_RX);

    // Transaction sequencer: advances one quarter-bit per tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            seg_q   <= SEG_ADDRW;
            q_q     <= '0;
            bitn_q  <= '0;
            sh_q    <= '0;
            rd_q    <= 1'b0;
            err_q   <= 1'b0;
            scl_oe  <= 1'b0;
            sda_oe  <= 1'b0;
            done    <= 1'b0;
            rx_byte <= '0;
        end else begin
            done <= 1'b0;
            if (st_q == ST_IDLE) begin
                if (go) begin
                    st_q  <= ST_START;
                    q_q   <= '0;
                    err_q <= 1'b0;
                    rd_q  <= slave_byte[0];
                end
            end else if (tick) begin
                q_q <= q_q + 1'b1;
                unique case (st_q)
                    ST_START: begin
                        if (q_q == 2'd2) sda_oe <= 1'b1;
                        if (q_q == 2'd3) begin
                            st_q   <= ST_TX;
                            seg_q  <= SEG_ADDRW;
                            sh_q   <= {slave_byte[DW-1:1], 1'b0};
                            bitn_q <= '0;
                        end
                    end
                    ST_TX: begin
                        unique case (q_q)
                            2'd0: scl_oe <= 1'b1;
                            2'd1: sda_oe <= (bitn_q != ACK_SLOT) ? ~sh_q[DW-1] : 1'b0;
                            2'd2: scl_oe <= 1'b0;
                            default: begin
                                if (bitn_q != ACK_SLOT) begin
                                    sh_q   <= {sh_q[DW-2:0], 1'b0};
                                    bitn_q <= bitn_q + 1'b1;
                                end else begin
                                    bitn_q <= '0;
                                    if (sda_in) begin
                                        err_q <= 1'b1;
                                        st_q  <= ST_STOP;
                                    end else begin
                                        unique case (seg_q)
                                            SEG_ADDRW: begin
                                                seg_q <= SEG_INDEX;
                                                sh_q  <= index_byte;
                                            end
                                            SEG_INDEX: begin
                                                if (rd_q) st_q <= ST_RSTART;
                                                else begin
                                                    seg_q <= SEG_DATA;
                                                    sh_q  <= data_byte;
                                                end
                                            end
                                            SEG_DATA:  st_q <= ST_STOP;
                                            default:   st_q <= ST_RX;
                                        endcase
                                    end
                                end
                            end
                        endcase
                    end
                    ST_RSTART: begin
                        unique case (q_q)
                            2'd0: scl_oe <= 1'b1;
                            2'd1: sda_oe <= 1'b0;
                            2'd2: scl_oe <= 1'b0;
                            default: begin
                                sda_oe <= 1'b1;
                                st_q   <= ST_TX;
                                seg_q  <= SEG_ADDRR;
                                sh_q   <= {slave_byte[DW-1:1], 1'b1};
                                bitn_q <= '0;
                            end
                        endcase
                    end
                    ST_RX: begin
                        unique case (q_q)
                            2'd0: scl_oe <= 1'b1;
                            2'd1: sda_oe <= 1'b0;
                            2'd2: scl_oe <= 1'b0;
                            default: begin
                                if (bitn_q != ACK_SLOT) begin
                                    rx_byte <= {rx_byte[DW-2:0], sda_in};
                                    bitn_q  <= bitn_q + 1'b1;
                                end else begin
                                    bitn_q <= '0;
                                    st_q   <= ST_STOP;
                                end
                            end
                        endcase
                    end
                    ST_STOP: begin
                        unique case (q_q)
                            2'd0: scl_oe <= 1'b1;
                            2'd1: sda_oe <= 1'b1;
                            2'd2: scl_oe <= 1'b0;
                            default: begin
                                sda_oe <= 1'b0;
                                st_q   <= ST_IDLE;
                                done   <= 1'b1;
                            end
                        endcase
                    end
                    default: st_q <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/sbus_byte_master.sv
`timescale 1ns/1ps
// Module: top of the register-driven two-wire byte master.
// Connects the host register file, the quarter-bit divider and the bus
// engine. The bus lines are open-drain: an output enable of 1 pulls the
// line low. Assumes an external pull-up on both lines.
module sbus_byte_master
    import sbm_pkg::*;
#(
    parameter int CLK_DIV = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          scl_oe,
    output logic          sda_oe,
    input  logic          sda_in
);
    logic          tick_w;
    logic          go_w;
    logic          busy_w;
    logic          err_w;
    logic          done_w;
    logic          done_err_w;
    logic          done_read_w;
    logic          in_data_w;
    logic [DW-1:0] rx_w;
    logic [DW-1:0] data_w;
    logic [DW-1:0] index_w;
    logic [DW-1:0] slave_w;

    sbm_tick #(.DIV(CLK_DIV)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick_w)
    );

    sbm_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_wr   (reg_wr),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .done     (done_w),
        .done_err (done_err_w),
        .done_read(done_read_w),
        .rx_byte  (rx_w),
        .go       (go_w),
        .busy     (busy_w),
        .err      (err_w),
        .data_q   (data_w),
        .index_q  (index_w),
        .slave_q  (slave_w)
    );

    sbm_engine u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick_w),
        .go        (go_w),
        .slave_byte(slave_w),
        .index_byte(index_w),
        .data_byte (data_w),
        .sda_in    (sda_in),
        .scl_oe    (scl_oe),
        .sda_oe    (sda_oe),
        .done      (done_w),
        .done_err  (done_err_w),
        .done_read (done_read_w),
        .rx_byte   (rx_w),
        .in_data   (in_data_w)
    );
endmodule

// File: rtl/sbm_checker.sv
`timescale 1ns/1ps
// Module: assertion checker for sbus_byte_master, bound to the top.
module sbm_checker
    import sbm_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic          reg_wr,
    input logic [AW-1:0] reg_addr,
    input logic [DW-1:0] reg_wdata,
    input logic          busy,
    input logic          err,
    input logic          done,
    input logic [DW-1:0] data_q,
    input logic [DW-1:0] index_q,
    input logic [DW-1:0] slave_q,
    input logic          scl_oe,
    input logic          sda_oe,
    input logic          in_data
);
    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!scl_oe && !sda_oe)); // R1

    AST_LAUNCH_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFS_SLAVE && !busy) |=> busy); // R2

    AST_BUSY_UNTIL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy); // R2

    AST_LOCKED_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done && reg_wr && reg_addr != OFS_CTRL)
        |=> ($stable(data_q) && $stable(index_q) && $stable(slave_q))); // R5

    AST_DONE_RELEASES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!scl_oe && !sda_oe)); // R6

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !(reg_wr && reg_addr == OFS_CTRL && reg_wdata[ERR_BIT])) |=> err); // R8

    AST_SDA_STILL_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (in_data && $past(in_data) && !scl_oe && !$past(scl_oe)) |-> $stable(sda_oe)); // R9
endmodule

bind sbus_byte_master sbm_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .busy     (busy_w),
    .err      (err_w),
    .done     (done_w),
    .data_q   (data_w),
    .index_q  (index_w),
    .slave_q  (slave_w),
    .scl_oe   (scl_oe),
    .sda_oe   (sda_oe),
    .in_data  (in_data_w)
);

// File: tb/sbus_byte_master_tb.sv
`timescale 1ns/1ps
// Bench: scoreboard driven. The driver pushes expected register results and
// the observed ones; a monitor pops and compares them. A behavioural bus
// device with 16 bytes of memory sits on the open-drain lines.
module sbus_byte_master_tb;
    localparam int CLK_DIV = 4;
    localparam logic [6:0] DEV  = 7'h52;
    localparam logic [6:0] NODEV = 7'h11;

    typedef struct {
        string       req;
        logic [7:0]  data;
        logic [7:0]  stat;
    } item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       scl_oe, sda_oe;
    logic       slv_oe = 1'b0;
    logic       scl_w, sda_w;

    int checks = 0;
    int errors = 0;
    item_t exp_q[$];
    item_t obs_q[$];

    always #2.5 clk = ~clk;

    assign scl_w = ~scl_oe;
    assign sda_w = ~(sda_oe | slv_oe);

    sbus_byte_master #(.CLK_DIV(CLK_DIV)) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_wr   (reg_wr),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .scl_oe   (scl_oe),
        .sda_oe   (sda_oe),
        .sda_in   (sda_w)
    );

    // ---------------- behavioural bus device ----------------
    logic [7:0] mem [16];
    int         d_st = 0;   // 0 idle, 1 addr, 2 index, 3 wdata, 4 rdata
    int         d_nxt = 0;
    int         d_k = 0;
    logic [7:0] d_sh = 8'd0;
    logic [3:0] d_ptr = 4'd0;
    logic       nack_data = 1'b0;
    int         n_start = 0;
    int         n_stop = 0;
    realtime    t_rise0 = 0.0;
    realtime    t_rise1 = 0.0;

    initial for (int i = 0; i < 16; i++) mem[i] = 8'h40 + 8'(i * 3);

    always @(negedge sda_w) if (scl_w) begin
        n_start++;
        d_st = 1; d_k = 0; slv_oe = 1'b0;
    end

    always @(posedge sda_w) if (scl_w) begin
        n_stop++;
        d_st = 0; d_k = 0; slv_oe = 1'b0;
    end

    always @(posedge scl_w) begin
        t_rise0 = t_rise1;
        t_rise1 = $realtime;
        if (d_st != 0) begin
            if (d_st != 4 && d_k < 8) d_sh = {d_sh[6:0], sda_w};
            d_k++;
        end
    end

    always @(negedge scl_w) begin
        if (d_st == 4) begin
            if (d_k >= 1 && d_k < 8) slv_oe = ~mem[d_ptr][7 - d_k];
            else if (d_k == 8) slv_oe = 1'b0;
            else if (d_k == 9) begin d_st = 0; d_k = 0; end
        end else if (d_st != 0) begin
            if (d_k == 8) begin
                slv_oe = 1'b0;
                d_nxt  = 0;
                if (d_st == 1) begin
                    if (d_sh[7:1] == DEV) begin
                        slv_oe = 1'b1;
                        d_nxt  = d_sh[0] ? 4 : 2;
                    end
                end else if (d_st == 2) begin
                    d_ptr = d_sh[3:0]; slv_oe = 1'b1; d_nxt = 3;
                end else if (!nack_data) begin
                    mem[d_ptr] = d_sh; slv_oe = 1'b1;
                end
            end else if (d_k == 9) begin
                slv_oe = 1'b0; d_k = 0; d_st = d_nxt;
                if (d_st == 4) slv_oe = ~mem[d_ptr][7];
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [7:0] s;
        do reg_read(2'd3, s); while (s[5]);
    endtask

    // Runs one transaction, pushes expected and observed register results.
    task automatic txn(input bit rd, input logic [6:0] dev, input logic [7:0] idx,
                       input logic [7:0] dat, input logic [7:0] exp_data,
                       input logic [7:0] exp_stat, input string req);
        logic [7:0] s, d;
        if (!rd) reg_write(2'd0, dat);
        reg_write(2'd1, idx);
        reg_write(2'd2, {dev, rd});
        reg_read(2'd3, s);
        chk(s[5] == 1'b1, "R2 busy after launch", s[5], 1);
        exp_q.push_back('{req, exp_data, exp_stat});
        wait_idle();
        reg_read(2'd0, d);
        reg_read(2'd3, s);
        obs_q.push_back('{req, d, s});
    endtask

    // Monitor: compares each observed result against the expected one.
    initial begin
        forever begin
            @(posedge clk);
            while (obs_q.size() != 0 && exp_q.size() != 0) begin
                item_t e, o;
                e = exp_q.pop_front();
                o = obs_q.pop_front();
                chk(o.data == e.data, {e.req, " data reg"}, o.data, e.data);
                chk(o.stat == e.stat, {e.req, " status reg"}, o.stat, e.stat);
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // ---------------- stimulus ----------------
    initial begin
        logic [7:0] v;
        int s0, p0;
        repeat (4) @(posedge clk);
        rst_n = 1'b1;

        // R1 reset state
        reg_read(2'd3, v); chk(v == 8'h00, "R1 status after reset", v, 0);
        reg_read(2'd0, v); chk(v == 8'h00, "R1 data after reset", v, 0);
        chk(scl_w && sda_w, "R1 bus released", {scl_w, sda_w}, 3);

        // R3 write, R9 one start and one stop
        s0 = n_start; p0 = n_stop;
        txn(1'b0, DEV, 8'h03, 8'hA5, 8'hA5, 8'h00, "R3 write");
        chk(mem[3] == 8'hA5, "R3 device memory", mem[3], 8'hA5);
        chk(n_start - s0 == 1 && n_stop - p0 == 1, "R9 write conditions",
            (n_start - s0) * 16 + (n_stop - p0), 17);
        chk($realtime - 0.0 > 0.0 && (t_rise1 - t_rise0) == real'(4 * CLK_DIV) * 5.0,
            "R10 bus clock period", int'(t_rise1 - t_rise0), 4 * CLK_DIV * 5);

        // R4 reads, R9 two starts and one stop
        s0 = n_start; p0 = n_stop;
        txn(1'b1, DEV, 8'h03, 8'h00, 8'hA5, 8'h00, "R4 read back");
        chk(n_start - s0 == 2 && n_stop - p0 == 1, "R9 read conditions",
            (n_start - s0) * 16 + (n_stop - p0), 33);
        txn(1'b1, DEV, 8'h09, 8'h00, 8'h40 + 8'd27, 8'h00, "R4 read preset");

        // R5 writes while busy are ignored
        s0 = n_start;
        reg_write(2'd0, 8'h3C);
        reg_write(2'd1, 8'h05);
        reg_write(2'd2, {DEV, 1'b0});
        reg_write(2'd0, 8'hFF);
        reg_write(2'd1, 8'h07);
        reg_write(2'd2, {DEV, 1'b1});
        wait_idle();
        repeat (400) @(posedge clk);
        reg_read(2'd0, v); chk(v == 8'h3C, "R5 data reg kept", v, 8'h3C);
        reg_read(2'd1, v); chk(v == 8'h05, "R5 index reg kept", v, 8'h05);
        reg_read(2'd2, v); chk(v == {DEV, 1'b0}, "R5 slave reg kept", v, {DEV, 1'b0});
        chk(mem[5] == 8'h3C, "R5 first write landed", mem[5], 8'h3C);
        chk(mem[7] == 8'h40 + 8'd21, "R5 index 7 untouched", mem[7], 8'h40 + 8'd21);
        chk(n_start - s0 == 1, "R5 single transaction", n_start - s0, 1);

        // R6 address not acknowledged
        txn(1'b0, NODEV, 8'h02, 8'h99, 8'h99, 8'h10, "R6 address nack");
        chk(mem[2] == 8'h46, "R6 memory untouched", mem[2], 8'h46);
        chk(scl_w && sda_w, "R6 bus released", {scl_w, sda_w}, 3);

        // R8 sticky error, write-one-to-clear
        reg_write(2'd3, 8'h00);
        reg_read(2'd3, v); chk(v == 8'h10, "R8 zero write keeps error", v, 8'h10);
        reg_write(2'd3, 8'h10);
        reg_read(2'd3, v); chk(v == 8'h00, "R8 one write clears error", v, 0);

        // R7 data byte not acknowledged
        nack_data = 1'b1;
        p0 = n_stop;
        txn(1'b0, DEV, 8'h04, 8'h77, 8'h77, 8'h10, "R7 data nack");
        nack_data = 1'b0;
        chk(mem[4] == 8'h4C, "R7 memory untouched", mem[4], 8'h4C);
        chk(n_stop - p0 == 1, "R7 stop issued", n_stop - p0, 1);
        reg_write(2'd3, 8'h10);

        // R4 read after an error still works
        txn(1'b1, DEV, 8'h05, 8'h00, 8'h3C, 8'h00, "R4 read after error");

        repeat (4) @(posedge clk);
        chk(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule